// File: doc/BRIEF.md
# Two-Stage Horizontal Line Resizer

This block resizes one line of 8-bit pixels along the horizontal axis. Pixels arrive on a valid/ready stream that carries a line-start flag and a line-end flag. They first pass through up to two halving stages. Each active stage replaces every pair of neighbouring pixels by their rounded mean. A fractional-step interpolator then walks the reduced line with a fixed-point position and blends the two pixels around each position. It emits exactly the requested number of output pixels, and the last of them carries a line-end flag.

Both stages are steered by a 16-bit resize word. The upper two bits select how many halvings to apply. The lower fourteen bits hold the interpolation step, which has 13 fraction bits. A built-in calculator derives this word from an input width and an output width, and rejects ratios the datapath cannot serve. Software can load the computed word back into the datapath, or supply a word of its own.

Top module: `line_resizer`

## Requirements
- R1: A pulse on `calc_go` while `calc_busy` is low starts a calculation on the present widths. The result appears with a one-cycle `calc_done` pulse, during which `calc_busy` is low. `calc_reject` is set when the input width is 0 or above 4096, or when the output width is below 2 or above 1024.
- R2: `calc_reject` is also set when four times the output width is smaller than the input width, that is, when the reduction exceeds 4:1.
- R3: The halving count starts at 0. While the working width is above 1024, or is at least twice the output width, the working width is halved (rounding down) and the count rises by one. At most two halvings are made, so the count in `calc_field[15:14]` is 0, 1 or 2.
- R4: The step in `calc_field[13:0]` is floor(8192 × (working width − 1) / (output width − 1)).
- R5: A step of 16384 or more is replaced by 0x3FFF.
- R6: `rsz_field[15:14]` selects the halving count, and the value 3 acts as 2. Each halving outputs (a + b + 1) >> 1 for pixel pairs (0,1), (2,3) and so on. A trailing unpaired pixel passes through unchanged.
- R7: Output pixel k uses the position P = k × step, where step is `rsz_field[13:0]`. With i = P >> 13 and f = bits 12:9 of P, the output is (a × (16 − f) + b × f + 8) >> 4, where a is reduced pixel i and b is reduced pixel i+1.
- R8: Each line yields exactly `cfg_out_width` output pixels, and `m_eol` is set only on the last one. Reduced-pixel indices past the end of the line read the last reduced pixel. Input left over after the last output is accepted and discarded, up to and including the line end.
- R9: A pixel flagged with `s_sol` restarts the position, the output count and the halving pair phase, even in the middle of an unfinished line.
- R10: After reset `m_valid` and `calc_done` are low. While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_eol` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_in_width | input | 13 | Calculator input width in pixels |
| cfg_out_width | input | 11 | Output width, used by the calculator and the datapath |
| calc_go | input | 1 | Start a calculation |
| calc_busy | output | 1 | Calculation in progress |
| calc_done | output | 1 | One-cycle result pulse |
| calc_reject | output | 1 | Requested ratio is unsupported |
| calc_field | output | 16 | Computed resize word: halving count in 15:14, step in 13:0 |
| rsz_field | input | 16 | Resize word applied to the datapath |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted |
| s_data | input | 8 | Input pixel |
| s_sol | input | 1 | First pixel of a line |
| s_eol | input | 1 | Last pixel of a line |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Output pixel taken |
| m_data | output | 8 | Output pixel |
| m_eol | output | 1 | Last output pixel of a line |

## Verification
A line-start pixel can arrive while the interpolator still owes output pixels for an unfinished line. In that cycle the restart must win over the pending line, and no stale pair phase or position may leak into the next line. The bench provokes this by holding `m_ready` low and feeding a single pixel that has no line end, then starting a full line. It judges the result by comparing every pixel of the new line against a model of the requirements. Lines that end before their outputs finish, and lines that carry input past the last output, exercise both ways in which line-end handling and output counting can end the line.

// File: rtl/lr_pkg.sv
package lr_pkg;
  localparam int PIX_W     = 8;
  localparam int FRAC_W    = 13;
  localparam int STEP_W    = 14;
  localparam int CODE_W    = 2;
  localparam int WGT_W     = 4;
  localparam int IN_W      = 13;
  localparam int OUT_W     = 11;
  localparam int MAX_HALVE = 2;
  localparam int MAX_IN    = 4096;
  localparam int MAX_OUT   = 1024;
  localparam int FIELD_W   = CODE_W + STEP_W;

  typedef enum logic [1:0] {RS_IDLE, RS_RUN, RS_DRAIN} rs_state_e;
  typedef enum logic       {CC_IDLE, CC_DIV} cc_state_e;
endpackage

// File: rtl/lr_halver.sv
module lr_halver #(
  parameter int PW = lr_pkg::PIX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  input  logic          in_sol,
  input  logic          in_eol,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data,
  output logic          out_sol,
  output logic          out_eol
);
  logic          phase_q, phase_n;
  logic [PW-1:0] hold_q, hold_n;
  logic          hsol_q, hsol_n;
  logic          first, absorb, fire;
  logic [PW:0]   pair_sum;

  // a pixel opens a pair when it starts a line or the phase is even
  assign first    = in_sol || !phase_q;
  assign absorb   = en && first && !in_eol;
  assign out_valid = in_valid && !absorb;
  assign in_ready  = absorb ? 1'b1 : out_ready;
  assign fire      = in_valid && in_ready;
  assign pair_sum  = {1'b0, hold_q} + {1'b0, in_data} + {{PW{1'b0}}, 1'b1};

  always_comb begin
    if (!en || first) begin
      out_data = in_data;
      out_sol  = in_sol;
    end else begin
      out_data = pair_sum[PW:1];
      out_sol  = hsol_q;
    end
    out_eol = in_eol;
  end

  always_comb begin
    phase_n = phase_q;
    hold_n  = hold_q;
    hsol_n  = hsol_q;
    if (fire) begin
      phase_n = absorb;
      if (absorb) begin
        hold_n = in_data;
        hsol_n = in_sol;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      hold_q  <= '0;
      hsol_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      hold_q  <= hold_n;
      hsol_q  <= hsol_n;
    end
  end
endmodule

// File: rtl/lr_interp.sv
module lr_interp
  import lr_pkg::*;
#(
  parameter int PW = PIX_W,
  parameter int FW = FRAC_W,
  parameter int SW = STEP_W,
  parameter int WW = WGT_W,
  parameter int OW = OUT_W,
  parameter int CW = IN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] step,
  input  logic [OW-1:0] last_idx,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  input  logic          in_sol,
  input  logic          in_eol,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data,
  output logic          out_eol
);
  localparam int AW  = OW + SW;
  localparam int IPW = AW - FW;
  localparam int BW  = PW + WW + 1;

  rs_state_e     st_q, st_n;
  logic [AW-1:0] acc_q, acc_n;
  logic [OW-1:0] k_q, k_n;
  logic [CW-1:0] n_q, n_n;
  logic [PW-1:0] prev_q, prev_n, last_q, last_n;
  logic          end_q, end_n;

  logic [CW-1:0] need_cnt;
  logic          need_more, in_fire, out_fire, clamp, at_last;
  logic [WW-1:0] wf;
  logic [WW:0]   wa;
  logic [PW-1:0] pa, pb;
  logic [BW-1:0] blend;

  assign need_cnt  = CW'(acc_q[AW-1:FW]) + CW'(2);
  assign need_more = !end_q && (n_q < need_cnt);
  assign in_ready  = (st_q != RS_RUN) || need_more;
  assign out_valid = (st_q == RS_RUN) && !need_more;
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign at_last   = (k_q == last_idx);
  assign out_eol   = at_last;

  // when the line ended short of pixel i+1 both taps read the last pixel
  assign clamp = (n_q < need_cnt);
  assign pa    = clamp ? last_q : prev_q;
  assign pb    = last_q;
  assign wf    = acc_q[FW-1 -: WW];
  assign wa    = (WW+1)'(1 << WW) - {1'b0, wf};
  assign blend = BW'(pa) * BW'(wa) + BW'(pb) * BW'(wf) + BW'(1 << (WW-1));
  assign out_data = blend[WW +: PW];

  always_comb begin
    st_n   = st_q;
    acc_n  = acc_q;
    k_n    = k_q;
    n_n    = n_q;
    prev_n = prev_q;
    last_n = last_q;
    end_n  = end_q;
    if (in_fire) begin
      if (in_sol) begin
        st_n   = RS_RUN;
        acc_n  = '0;
        k_n    = '0;
        n_n    = CW'(1);
        last_n = in_data;
        end_n  = in_eol;
      end else if (st_q == RS_RUN) begin
        prev_n = last_q;
        last_n = in_data;
        n_n    = n_q + CW'(1);
        end_n  = in_eol;
      end else if (st_q == RS_DRAIN && in_eol) begin
        st_n = RS_IDLE;
      end
    end
    if (out_fire) begin
      acc_n = acc_q + AW'(step);
      k_n   = k_q + OW'(1);
      if (at_last) st_n = end_q ? RS_IDLE : RS_DRAIN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RS_IDLE;
      acc_q  <= '0;
      k_q    <= '0;
      n_q    <= '0;
      prev_q <= '0;
      last_q <= '0;
      end_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      acc_q  <= acc_n;
      k_q    <= k_n;
      n_q    <= n_n;
      prev_q <= prev_n;
      last_q <= last_n;
      end_q  <= end_n;
    end
  end
endmodule

// File: rtl/lr_coeff_calc.sv
module lr_coeff_calc
  import lr_pkg::*;
#(
  parameter int IW = IN_W,
  parameter int OW = OUT_W,
  parameter int FW = FRAC_W,
  parameter int SW = STEP_W,
  parameter int KW = CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    in_w,
  input  logic [OW-1:0]    out_w,
  input  logic             go,
  output logic             busy,
  output logic             done,
  output logic             reject,
  output logic [KW+SW-1:0] field
);
  localparam int NW   = IW - 1 + FW;
  localparam int CNTW = $clog2(NW + 1);
  localparam int XW   = IW + 1;

  cc_state_e          st_q, st_n;
  logic [NW-1:0]      num_q, num_n;
  logic [OW-1:0]      rem_q, rem_n, den_q, den_n;
  logic [CNTW-1:0]    cnt_q, cnt_n;
  logic [KW-1:0]      code_q, code_n;
  logic               done_q, done_n, rej_q, rej_n;
  logic [KW+SW-1:0]   field_q, field_n;

  logic [XW-1:0] out_x2, out_x4;
  logic [IW-1:0] tw1, tw2;
  logic          h1, h2, bad;
  logic [OW:0]   trial;
  logic          take;
  logic [NW-1:0] num_sh;

  assign out_x2 = XW'(out_w) << 1;
  assign out_x4 = XW'(out_w) << 2;
  assign bad = (XW'(in_w) > XW'(MAX_IN)) || (XW'(out_w) > XW'(MAX_OUT)) ||
               (out_w < OW'(2)) || (in_w == '0) || (out_x4 < XW'(in_w));
  assign h1  = (XW'(in_w) > XW'(MAX_OUT)) || (XW'(in_w) >= out_x2);
  assign tw1 = h1 ? (in_w >> 1) : in_w;
  assign h2  = h1 && ((XW'(tw1) > XW'(MAX_OUT)) || (XW'(tw1) >= out_x2));
  assign tw2 = h2 ? (tw1 >> 1) : tw1;

  // one restoring division step per cycle; quotient bits shift into num
  assign trial  = {rem_q, num_q[NW-1]};
  assign take   = trial >= {1'b0, den_q};
  assign num_sh = {num_q[NW-2:0], take};

  always_comb begin
    st_n    = st_q;
    num_n   = num_q;
    rem_n   = rem_q;
    den_n   = den_q;
    cnt_n   = cnt_q;
    code_n  = code_q;
    done_n  = 1'b0;
    rej_n   = rej_q;
    field_n = field_q;
    if (st_q == CC_IDLE) begin
      if (go) begin
        if (bad) begin
          done_n  = 1'b1;
          rej_n   = 1'b1;
          field_n = '0;
        end else begin
          st_n   = CC_DIV;
          num_n  = NW'(tw2 - IW'(1)) << FW;
          rem_n  = '0;
          den_n  = out_w - OW'(1);
          cnt_n  = CNTW'(NW - 1);
          code_n = {h2, h1 && !h2};
        end
      end
    end else begin
      num_n = num_sh;
      rem_n = take ? OW'(trial - {1'b0, den_q}) : OW'(trial);
      cnt_n = cnt_q - CNTW'(1);
      if (cnt_q == '0) begin
        st_n    = CC_IDLE;
        done_n  = 1'b1;
        rej_n   = 1'b0;
        field_n = {code_q, (|num_sh[NW-1:SW]) ? {SW{1'b1}} : num_sh[SW-1:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CC_IDLE;
      num_q   <= '0;
      rem_q   <= '0;
      den_q   <= '0;
      cnt_q   <= '0;
      code_q  <= '0;
      done_q  <= 1'b0;
      rej_q   <= 1'b0;
      field_q <= '0;
    end else begin
      st_q    <= st_n;
      num_q   <= num_n;
      rem_q   <= rem_n;
      den_q   <= den_n;
      cnt_q   <= cnt_n;
      code_q  <= code_n;
      done_q  <= done_n;
      rej_q   <= rej_n;
      field_q <= field_n;
    end
  end

  assign busy   = (st_q != CC_IDLE);
  assign done   = done_q;
  assign reject = rej_q;
  assign field  = field_q;
endmodule

// File: rtl/line_resizer.sv
module line_resizer
  import lr_pkg::*;
#(
  parameter int PW = PIX_W,
  parameter int IW = IN_W,
  parameter int OW = OUT_W,
  parameter int SW = STEP_W,
  parameter int KW = CODE_W,
  parameter int NH = MAX_HALVE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    cfg_in_width,
  input  logic [OW-1:0]    cfg_out_width,
  input  logic             calc_go,
  output logic             calc_busy,
  output logic             calc_done,
  output logic             calc_reject,
  output logic [KW+SW-1:0] calc_field,
  input  logic [KW+SW-1:0] rsz_field,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [PW-1:0]    s_data,
  input  logic             s_sol,
  input  logic             s_eol,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [PW-1:0]    m_data,
  output logic             m_eol
);
  logic [KW-1:0] code;
  logic [SW-1:0] step;
  logic [OW-1:0] last_idx;
  logic [NH:0]   hv, hr, hs, he;
  logic [PW-1:0] hd [NH+1];

  assign code     = rsz_field[KW+SW-1:SW];
  assign step     = rsz_field[SW-1:0];
  assign last_idx = (cfg_out_width == '0) ? '0 : cfg_out_width - OW'(1);

  lr_coeff_calc #(.IW(IW), .OW(OW), .SW(SW), .KW(KW)) i_calc (
    .clk, .rst_n, .in_w(cfg_in_width), .out_w(cfg_out_width), .go(calc_go),
    .busy(calc_busy), .done(calc_done), .reject(calc_reject), .field(calc_field)
  );

  assign hv[0]   = s_valid;
  assign hd[0]   = s_data;
  assign hs[0]   = s_sol;
  assign he[0]   = s_eol;
  assign s_ready = hr[0];

  for (genvar g = 0; g < NH; g++) begin : g_halve
    lr_halver #(.PW(PW)) i_halver (
      .clk, .rst_n, .en(code > KW'(g)),
      .in_valid(hv[g]), .in_ready(hr[g]), .in_data(hd[g]),
      .in_sol(hs[g]), .in_eol(he[g]),
      .out_valid(hv[g+1]), .out_ready(hr[g+1]), .out_data(hd[g+1]),
      .out_sol(hs[g+1]), .out_eol(he[g+1])
    );
  end

  lr_interp #(.PW(PW), .SW(SW), .OW(OW), .CW(IW)) i_interp (
    .clk, .rst_n, .step, .last_idx,
    .in_valid(hv[NH]), .in_ready(hr[NH]), .in_data(hd[NH]),
    .in_sol(hs[NH]), .in_eol(he[NH]),
    .out_valid(m_valid), .out_ready(m_ready), .out_data(m_data), .out_eol(m_eol)
  );
endmodule

// File: rtl/lr_checker.sv
module lr_checker #(
  parameter int PW = lr_pkg::PIX_W,
  parameter int IW = lr_pkg::IN_W,
  parameter int OW = lr_pkg::OUT_W,
  parameter int FW = lr_pkg::FIELD_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic [IW-1:0] cfg_in_width,
  input logic [OW-1:0] cfg_out_width,
  input logic          calc_go,
  input logic          calc_busy,
  input logic          calc_done,
  input logic          calc_reject,
  input logic [FW-1:0] calc_field,
  input logic          m_valid,
  input logic          m_ready,
  input logic [PW-1:0] m_data,
  input logic          m_eol
);
  localparam int XW = IW + 2;
  logic [IW-1:0] lat_in;
  logic [OW-1:0] lat_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_in  <= '0;
      lat_out <= '0;
    end else if (calc_go && !calc_busy) begin
      lat_in  <= cfg_in_width;
      lat_out <= cfg_out_width;
    end
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_eol));

  a_r1_limits: assert property (@(posedge clk) disable iff (!rst_n)
    calc_done && (XW'(lat_in) > XW'(4096) || XW'(lat_out) > XW'(1024) ||
                  lat_out < OW'(2) || lat_in == '0) |-> calc_reject);

  a_r1_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    calc_done |-> !calc_busy);

  a_r2_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    calc_done && (XW'(lat_out) * XW'(4) < XW'(lat_in)) |-> calc_reject);

  a_r3_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    calc_done && !calc_reject |-> calc_field[FW-1:FW-2] != 2'b11);
endmodule

bind line_resizer lr_checker i_lr_checker (
  .clk(clk), .rst_n(rst_n), .cfg_in_width(cfg_in_width), .cfg_out_width(cfg_out_width),
  .calc_go(calc_go), .calc_busy(calc_busy), .calc_done(calc_done),
  .calc_reject(calc_reject), .calc_field(calc_field),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_eol(m_eol)
);

// File: tb/test_line_resizer.sv
`timescale 1ns/1ps
module test_line_resizer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [12:0] cfg_in_width;
  logic [10:0] cfg_out_width;
  logic        calc_go;
  logic        calc_busy, calc_done, calc_reject;
  logic [15:0] calc_field;
  logic [15:0] rsz_field;
  logic        s_valid, s_ready, s_sol, s_eol;
  logic [7:0]  s_data;
  logic        m_valid, m_ready, m_eol;
  logic [7:0]  m_data;

  int n_chk = 0;
  int n_fail = 0;
  int src [64];
  int expv [64];

  always #5 clk = ~clk;

  line_resizer i_line_resizer (
    .clk, .rst_n, .cfg_in_width, .cfg_out_width, .calc_go, .calc_busy, .calc_done,
    .calc_reject, .calc_field, .rsz_field, .s_valid, .s_ready, .s_data, .s_sol,
    .s_eol, .m_valid, .m_ready, .m_data, .m_eol
  );

  // {in width, out width, reject, expected word}
  localparam logic [40:0] CALC_TAB [13] = '{
    {13'd640,  11'd320,  1'b0, 16'h6000},  // R3 one halving
    {13'd100,  11'd100,  1'b0, 16'h2000},  // R4 unity
    {13'd4096, 11'd1024, 1'b0, 16'hA000},  // R3 two halvings, width cap
    {13'd100,  11'd30,   1'b0, 16'h7611},  // R4 floor division
    {13'd10,   11'd4,    1'b0, 16'h6AAA},  // R4
    {13'd2,    11'd5,    1'b0, 16'h0800},  // R4 enlarge
    {13'd400,  11'd100,  1'b0, 16'hA000},  // R2 exact 4:1 allowed
    {13'd3,    11'd2,    1'b0, 16'h3FFF},  // R5 saturation
    {13'd4097, 11'd1024, 1'b1, 16'h0000},  // R1 input too wide
    {13'd1000, 11'd1025, 1'b1, 16'h0000},  // R1 output too wide
    {13'd401,  11'd100,  1'b1, 16'h0000},  // R2 beyond 4:1
    {13'd4,    11'd1,    1'b1, 16'h0000},  // R1 output below 2
    {13'd0,    11'd8,    1'b1, 16'h0000}   // R1 empty input
  };
  localparam string CALC_REQ [13] = '{"R3", "R4", "R3", "R4", "R4", "R4", "R2",
                                      "R5", "R1", "R1", "R2", "R1", "R1"};

  // {code, step, out width, length, seed, stall}
  localparam int LINE_TAB [9][6] = '{
    '{0, 'h2000, 8, 8,  1, 0},
    '{1, 'h2000, 8, 16, 2, 1},
    '{2, 'h2000, 4, 16, 3, 0},
    '{0, 'h1000, 9, 5,  4, 1},
    '{1, 'h2000, 4, 7,  5, 0},
    '{1, 'h2AAA, 4, 10, 6, 1},
    '{3, 'h2000, 2, 8,  7, 0},
    '{0, 'h3FFF, 4, 3,  8, 1},
    '{0, 'h1000, 3, 8,  9, 0}
  };
  localparam string LINE_REQ [9] = '{"R7", "R6", "R6", "R7", "R6", "R7", "R6", "R8", "R8"};

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fill_src(input int len, input int seed);
    for (int i = 0; i < len; i++)
      src[i] = (i * 53 + seed * 29 + ((i % 3 == 0) ? 190 : 0)) % 256;
    if (seed % 2 == 1) src[0] = 255;
    if (len > 2) src[len-1] = 0;
  endtask

  // requirement model: halvings, then position-weighted blend with clamping
  task automatic build_expect(input int code, input int step, input int ow, input int len);
    int cur [64];
    int m;
    int lv;
    lv = (code == 0) ? 0 : ((code == 1) ? 1 : 2);
    m = len;
    for (int i = 0; i < len; i++) cur[i] = src[i];
    for (int l = 0; l < lv; l++) begin
      int nm;
      nm = (m + 1) / 2;
      for (int j = 0; j < nm; j++)
        cur[j] = (2*j + 1 < m) ? (cur[2*j] + cur[2*j+1] + 1) / 2 : cur[2*j];
      m = nm;
    end
    for (int k = 0; k < ow; k++) begin
      int pos, ip, f, a, b;
      pos = k * step;
      ip  = pos >> 13;
      f   = (pos >> 9) & 15;
      a   = cur[(ip < m) ? ip : m - 1];
      b   = cur[(ip + 1 < m) ? ip + 1 : m - 1];
      expv[k] = (a * (16 - f) + b * f + 8) >> 4;
    end
  endtask

  task automatic run_line(input int code, input int step, input int ow, input int len,
                          input int seed, input int stall, input string req);
    int idx, cnt, cyc;
    idx = 0; cnt = 0; cyc = 0;
    fill_src(len, seed);
    build_expect(code, step, ow, len);
    rsz_field = {code[1:0], step[13:0]};
    cfg_out_width = ow[10:0];
    while ((idx < len || cnt < ow) && cyc < 3000) begin
      @(negedge clk);
      s_valid = (idx < len) && !(stall != 0 && cyc % 3 == 1);
      s_data  = (idx < len) ? src[idx][7:0] : 8'h00;
      s_sol   = (idx == 0);
      s_eol   = (idx == len - 1);
      m_ready = !(stall != 0 && cyc % 4 == 2);
      #1;
      if (s_valid && s_ready) idx++;
      if (m_valid && m_ready) begin
        if (cnt < 64) begin
          chk(m_data == expv[cnt][7:0], req, "pixel", int'(m_data), expv[cnt]);
          chk(m_eol == (cnt == ow - 1), "R8", "eol flag", int'(m_eol), int'(cnt == ow - 1));
        end
        cnt++;
      end
      cyc++;
    end
    chk(cnt == ow, "R8", "output count", cnt, ow);
    @(negedge clk);
    s_valid = 1'b0;
    s_sol   = 1'b0;
    s_eol   = 1'b0;
  endtask

  task automatic run_calc(input int in_w, input int out_w, input bit exp_rej,
                          input int exp_field, input string req);
    int waitc;
    @(negedge clk);
    cfg_in_width  = in_w[12:0];
    cfg_out_width = out_w[10:0];
    calc_go = 1'b1;
    @(negedge clk);
    calc_go = 1'b0;
    waitc = 0;
    while (!calc_done && waitc < 100) begin
      @(negedge clk);
      waitc++;
    end
    chk(calc_done, req, "done pulse", int'(calc_done), 1);
    chk(calc_reject == exp_rej, req, "reject", int'(calc_reject), int'(exp_rej));
    if (!exp_rej)
      chk(calc_field == exp_field[15:0], req, "field", int'(calc_field), exp_field);
  endtask

  initial begin
    #1_500_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_in_width = '0;
    cfg_out_width = 11'd8;
    calc_go = 1'b0;
    rsz_field = 16'h2000;
    s_valid = 1'b0;
    s_data = '0;
    s_sol = 1'b0;
    s_eol = 1'b0;
    m_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!m_valid, "R10", "m_valid after reset", int'(m_valid), 0);
    chk(!calc_done, "R10", "calc_done after reset", int'(calc_done), 0);
    chk(!calc_busy, "R1", "calc_busy after reset", int'(calc_busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!m_valid, "R10", "m_valid idle", int'(m_valid), 0);

    for (int t = 0; t < 13; t++)
      run_calc(int'(CALC_TAB[t][40:28]), int'(CALC_TAB[t][27:17]), CALC_TAB[t][16],
               int'(CALC_TAB[t][15:0]), CALC_REQ[t]);

    for (int t = 0; t < 9; t++)
      run_line(LINE_TAB[t][0], LINE_TAB[t][1], LINE_TAB[t][2], LINE_TAB[t][3],
               LINE_TAB[t][4], LINE_TAB[t][5], LINE_REQ[t]);

    // R9: a lone pixel with no line end, then a fresh line restarts everything
    rsz_field = 16'h2000;
    cfg_out_width = 11'd4;
    @(negedge clk);
    m_ready = 1'b0;
    s_valid = 1'b1;
    s_data  = 8'hAB;
    s_sol   = 1'b1;
    s_eol   = 1'b0;
    @(negedge clk);
    s_valid = 1'b0;
    s_sol   = 1'b0;
    repeat (2) @(negedge clk);
    chk(!m_valid, "R9", "no output for lone pixel", int'(m_valid), 0);
    run_line(0, 'h2000, 4, 4, 11, 0, "R9");
    // R9: halving phase restarts after an odd abandoned line
    run_line(1, 'h2000, 3, 5, 12, 1, "R9");
    run_line(1, 'h2000, 4, 8, 13, 0, "R9");

    report();
    $finish;
  end
endmodule